// File: doc/BRIEF.md
# Floating-Point Issue Interval Tracker

This block guards the issue port of a floating-point execution cluster whose operation classes differ both in result latency and in how soon the same class may start again. For each class it keeps a countdown of the cycles left before a new operation may begin. In the same cycle as an issue request, it either grants the request or raises a structural stall. The arithmetic is done elsewhere. The block only decides when an operation may start and when its result becomes available.

For every granted operation the block produces a result-ready pulse for that class, exactly the class latency after the grant. The pulse carries the tag supplied at issue. Each class has its own pulse bit and tag field, so results of different classes that are due in the same cycle never collide. An operation of one class may still be in flight when the next operation of the same class starts, so each class tracks several outstanding operations.

Top module: `fp_ii_tracker`

## Requirements
- R1: After a synchronous active-low reset no result pulse appears, every class accepts its first request at once, and operations in flight when reset was applied never produce a pulse.
- R2: Class codes are: 0 add/subtract, 1 multiply, 2 divide, 3 square root, 4 negate/absolute value, 5 compare. A request with code 6 or 7 raises neither `issue_accept` nor `issue_stall` and never produces a result pulse.
- R3: A valid request whose class is idle is granted in the same cycle: `issue_accept` is high and `issue_stall` is low.
- R4: After a grant in cycle T, a request of the same class is stalled in cycles before T+II and granted from T+II on. II is 3 for add, 4 for multiply, 35 for divide, 111 for square root, 1 for negate and 2 for compare.
- R5: A class that is inside its interval does not stall a request of another class.
- R6: A grant in cycle T with tag X gives `done_valid[c]` high for exactly one cycle, in cycle T+L, with `done_tag[c*TAG_W +: TAG_W]` equal to X. L is 4 for add, 8 for multiply, 36 for divide, 112 for square root, 2 for negate and 3 for compare.
- R7: Two operations of the same class that are in flight together each produce their own pulse, in issue order, each with its own tag.
- R8: Results of different classes that are due in the same cycle appear together, each on its own `done_valid` bit.
- R9: `issue_accept` and `issue_stall` are never high together, and neither is high without `req_valid`.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Issue request present; must be held until it is accepted |
| req_class | input | 3 | Operation class code |
| req_tag | input | TAG_W | Tag returned with the result pulse |
| issue_accept | output | 1 | Request granted this cycle |
| issue_stall | output | 1 | Request refused this cycle because of a structural hazard |
| done_valid | output | NUM_CLASS | Result-ready pulse, one bit per class |
| done_tag | output | NUM_CLASS*TAG_W | Tag of each class's result, class c in bits c*TAG_W upward |

## Verification
If a class countdown is wrong, the error shows at the issue port. A retried request is granted one or more cycles too early or too late, and the per-cycle comparison catches it on that exact cycle. If a delay slot is wrong, the result pulse moves, goes missing or carries the wrong tag. This shows up at most one latency after the grant, which is up to 112 cycles for square root. The bench therefore keeps overlapping square-root operations in flight, and it also applies a reset while an operation is in flight, so that a lost or stale slot becomes visible.

// File: rtl/fp_ii_pkg.sv
// Shared constants for the FP issue interval tracker.
// Assumes class codes 0..NUM_CLASS-1 are dense; higher codes are invalid.
package fp_ii_pkg;
    localparam int NUM_CLASS = 6;
    localparam int CLASS_W   = 3;

    typedef enum logic [CLASS_W-1:0] {
        CL_ADD  = 3'd0,
        CL_MUL  = 3'd1,
        CL_DIV  = 3'd2,
        CL_SQRT = 3'd3,
        CL_NEG  = 3'd4,
        CL_CMP  = 3'd5
    } fp_class_e;

    // Cycles from grant to result for a class.
    function automatic int class_latency(input int c);
        case (c)
            0: return 4;
            1: return 8;
            2: return 36;
            3: return 112;
            4: return 2;
            default: return 3;
        endcase
    endfunction

    // Minimum spacing between two grants of a class.
    function automatic int class_interval(input int c);
        case (c)
            0: return 3;
            1: return 4;
            2: return 35;
            3: return 111;
            4: return 1;
            default: return 2;
        endcase
    endfunction

    // Operations of one class that can be in flight at once.
    function automatic int class_slots(input int c);
        return (class_latency(c) + class_interval(c) - 1) / class_interval(c);
    endfunction
endpackage

// File: rtl/fp_ii_gate.sv
// Per-class interval gate. A down-counter is loaded with INTERVAL-1 on
// a grant and counts to zero; the class is ready only at zero.
// Assumes INTERVAL >= 1.
module fp_ii_gate #(
    parameter int INTERVAL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ready
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL + 1) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             grant;

    // Ready when no cycles of the interval remain.
    always_comb begin
        ready = (wait_cnt == '0);
        grant = req && ready;
    end

    // Reload on grant, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (grant) begin
            wait_cnt <= RELOAD;
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // R4
    busy_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (INTERVAL > 1)) |=> !ready);

    // R4
    single_cycle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (INTERVAL == 1)) |=> ready);
endmodule

// File: rtl/fp_ii_delay.sv
// Per-class result delay tracker. Holds up to NSLOT outstanding grants,
// each with a countdown and a tag, and fires each one LATENCY cycles after
// its grant. Assumes grants are at least INTERVAL cycles apart and LATENCY >= 2.
module fp_ii_delay #(
    parameter int LATENCY  = 4,
    parameter int INTERVAL = 3,
    parameter int TAG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [TAG_W-1:0] take_tag,
    output logic             fire,
    output logic [TAG_W-1:0] fire_tag
);
    localparam int NSLOT = (LATENCY + INTERVAL - 1) / INTERVAL;
    localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int CD_W  = $clog2(LATENCY);
    localparam logic [CD_W-1:0]  CD_LOAD  = CD_W'(LATENCY - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NSLOT - 1);

    logic [NSLOT-1:0] slot_vld;
    logic [CD_W-1:0]  slot_cd  [NSLOT];
    logic [TAG_W-1:0] slot_tag [NSLOT];
    logic [NSLOT-1:0] slot_fire;
    logic [PTR_W-1:0] wr_ptr;

    // A slot fires when valid and its countdown has reached zero.
    always_comb begin
        fire     = 1'b0;
        fire_tag = '0;
        for (int i = 0; i < NSLOT; i++) begin
            slot_fire[i] = slot_vld[i] && (slot_cd[i] == '0);
            if (slot_fire[i]) begin
                fire     = 1'b1;
                fire_tag = slot_tag[i];
            end
        end
    end

    // Round-robin slot allocation, matching fixed-latency completion order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (take) begin
            wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Each slot: load on grant, count down, clear when it fires.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s] <= 1'b0;
                slot_cd[s]  <= '0;
                slot_tag[s] <= '0;
            end else if (take && (wr_ptr == PTR_W'(s))) begin
                slot_vld[s] <= 1'b1;
                slot_cd[s]  <= CD_LOAD;
                slot_tag[s] <= take_tag;
            end else if (slot_fire[s]) begin
                slot_vld[s] <= 1'b0;
            end else if (slot_vld[s]) begin
                slot_cd[s]  <= slot_cd[s] - 1'b1;
            end
        end
    end

    // R7
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_fire));

    // R7
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!slot_vld[wr_ptr] || slot_fire[wr_ptr]));

    // R6
    fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !take) |=> ($countones(slot_vld) < $countones($past(slot_vld))));
endmodule

// File: rtl/fp_ii_tracker.sv
// Structural hazard tracker for a multi-class FP issue port. Decodes the
// request class, grants it when that class's interval has elapsed and
// schedules a tagged result pulse per class. Assumes at most one request
// per cycle and that a stalled request is held unchanged until granted.
module fp_ii_tracker
    import fp_ii_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [CLASS_W-1:0]         req_class,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       issue_accept,
    output logic                       issue_stall,
    output logic [NUM_CLASS-1:0]       done_valid,
    output logic [NUM_CLASS*TAG_W-1:0] done_tag
);
    logic [NUM_CLASS-1:0] sel;
    logic [NUM_CLASS-1:0] ready;
    logic [NUM_CLASS-1:0] grant;

    // Decode the class code into a per-class request.
    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            sel[c] = req_valid && (req_class == CLASS_W'(c));
        end
    end

    // Combine per-class outcomes onto the issue port.
    always_comb begin
        grant        = sel & ready;
        issue_accept = |grant;
        issue_stall  = |(sel & ~ready);
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        fp_ii_gate #(
            .INTERVAL (class_interval(c))
        ) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (sel[c]),
            .ready (ready[c])
        );

        fp_ii_delay #(
            .LATENCY  (class_latency(c)),
            .INTERVAL (class_interval(c)),
            .TAG_W    (TAG_W)
        ) u_delay (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (grant[c]),
            .take_tag (req_tag),
            .fire     (done_valid[c]),
            .fire_tag (done_tag[c*TAG_W +: TAG_W])
        );
    end

    // R9
    accept_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_accept && issue_stall));

    // R2
    bad_class_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_class >= CLASS_W'(NUM_CLASS))) |-> !(issue_accept || issue_stall));

    // R4
    stall_then_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |=> (req_valid && $stable(req_class)));
endmodule

// File: tb/tb_fp_ii_tracker.sv
module tb_fp_ii_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W      = 8;
    localparam int NCLS       = 6;
    localparam int WATCHDOG   = 100000;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic [2:0]             req_class = '0;
    logic [TAG_W-1:0]       req_tag = '0;
    logic                   issue_accept;
    logic                   issue_stall;
    logic [NCLS-1:0]        done_valid;
    logic [NCLS*TAG_W-1:0]  done_tag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit first_after_reset = 1'b0;

    int lat_tab [NCLS] = '{4, 8, 36, 112, 2, 3};
    int ii_tab  [NCLS] = '{3, 4, 35, 111, 1, 2};
    int next_ok [NCLS];
    int due_q   [NCLS][$];
    int tag_q   [NCLS][$];

    fp_ii_tracker #(.TAG_W(TAG_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_class    (req_class),
        .req_tag      (req_tag),
        .issue_accept (issue_accept),
        .issue_stall  (issue_stall),
        .done_valid   (done_valid),
        .done_tag     (done_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int c = 0; c < NCLS; c++) begin
            next_ok[c] = 0;
            due_q[c].delete();
            tag_q[c].delete();
        end
    endtask

    // Reference model and comparison, once per cycle away from the edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            clear_model();
            first_after_reset = 1'b1;
        end else begin
            bit exp_acc, exp_stall, other_busy;
            int ndue;
            int cl;
            string lbl;
            cl = int'(req_class);
            exp_acc = 0;
            exp_stall = 0;
            other_busy = 0;
            if (req_valid && cl < NCLS) begin
                exp_acc   = (cyc >= next_ok[cl]);
                exp_stall = !exp_acc;
                for (int o = 0; o < NCLS; o++)
                    if (o != cl && cyc < next_ok[o]) other_busy = 1;
            end
            if (first_after_reset) begin
                check("R1", int'(done_valid), 0);
                first_after_reset = 1'b0;
            end
            if (req_valid && cl >= NCLS) lbl = "R2";
            else if (exp_stall) lbl = "R4";
            else if (exp_acc && other_busy) lbl = "R5";
            else lbl = "R3";
            check(lbl, int'(issue_accept), int'(exp_acc));
            check(lbl, int'(issue_stall), int'(exp_stall));
            check("R9", int'(issue_accept && issue_stall), 0);
            ndue = 0;
            for (int c = 0; c < NCLS; c++)
                if (due_q[c].size() > 0 && due_q[c][0] == cyc) ndue++;
            for (int c = 0; c < NCLS; c++) begin
                bit exp_d;
                exp_d = (due_q[c].size() > 0 && due_q[c][0] == cyc);
                if (ndue > 1) lbl = "R8";
                else if (due_q[c].size() > 1) lbl = "R7";
                else lbl = "R6";
                check(lbl, int'(done_valid[c]), int'(exp_d));
                if (exp_d) begin
                    check(lbl, int'(done_tag[c*TAG_W +: TAG_W]), tag_q[c][0]);
                    void'(due_q[c].pop_front());
                    void'(tag_q[c].pop_front());
                end
            end
            if (exp_acc) begin
                next_ok[cl] = cyc + ii_tab[cl];
                due_q[cl].push_back(cyc + lat_tab[cl]);
                tag_q[cl].push_back(int'(req_tag));
            end
        end
        cyc++;
    end

    // Present a request and hold it until granted (invalid codes: one cycle).
    task automatic issue(input int cls, input int tag);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_class = cls[2:0];
        req_tag   = tag[TAG_W-1:0];
        if (cls >= NCLS) begin
            @(negedge clk);
        end else begin
            do @(negedge clk); while (!issue_accept);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        // Back-to-back add: second and third stall for the interval (R4).
        issue(0, 8'h11); issue(0, 8'h12); issue(0, 8'h13);
        // Multiply while add is busy (R5), then retries.
        issue(1, 8'h21); issue(0, 8'h14); issue(1, 8'h22);
        // Negate every cycle, compare with interval 2.
        issue(4, 8'h31); issue(4, 8'h32); issue(4, 8'h33); issue(4, 8'h34);
        issue(5, 8'h35); issue(5, 8'h36); issue(5, 8'h37);
        // Invalid class codes (R2).
        issue(6, 8'hE6); issue(7, 8'hE7);
        idle(12);
        // Simultaneous completions: mul, add, neg all due together (R8).
        issue(1, 8'h51); idle(3); issue(0, 8'h52); idle(1); issue(4, 8'h53);
        idle(10);
        // Divide pair and overlapping square roots (R7).
        issue(2, 8'h61); issue(2, 8'h62);
        issue(3, 8'h71); issue(3, 8'h72);
        idle(240);
        // Reset with a square root in flight (R1).
        issue(3, 8'h81);
        idle(10);
        @(posedge clk); #1 rst_n = 1'b0;
        idle(2);
        @(posedge clk); #1 rst_n = 1'b1;
        idle(130);
        issue(3, 8'h82);
        idle(120);
        finish_run();
    end
endmodule